// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block sits on the host side of a linear photodiode array. It drives the array's serial start input and its pixel clock, and it tells a downstream converter when each pixel's analog level can be sampled. The array holds every pixel's charge at the start pulse. It then shifts one pixel to its output per clock rising edge and needs one extra edge to return the output to high impedance. The start-to-start interval sets how long light is integrated.

The system clock is divided into a sensor clock whose high and low phases each last `HALF` system cycles. The clock idles low between frames. A frame is requested with a one-cycle pulse. The sequencer launches it at the earliest instant the timing rules allow: the requested integration period plus the fixed reset offset must have elapsed since the previous start edge. Requests that arrive while a frame is in progress are held. In serial mode all `NPIX` pixels are read through one output. In parallel mode the two halves are read side by side, so a frame has `NPIX/2` pixel clocks and two indices per strobe. After reset a flush frame runs without any request and is never reported, because the array's content at power-up is meaningless.

Top module: `linsens_rdctl`

## Requirements
- R1: `sns_clk` is low whenever `busy` is low. Within a frame, every high phase and every low phase between rising edges lasts exactly `HALF` system cycles.
- R2: `sns_start` rises while `sns_clk` is low, `HALF` system cycles before the first rising edge of the frame. It falls on the same cycle as that edge's falling edge.
- R3: A frame has n+1 rising edges of `sns_clk`, where n = `NPIX` when `par_mode`=0 and n = `NPIX/2` when `par_mode`=1. `par_mode` is sampled when the frame is launched.
- R4: After each of the first n rising edges, `pix_strobe` is a one-cycle pulse exactly `STB_DLY` system cycles after the edge. `pix_idx` counts 0,1,…,n−1 across the frame. No strobe follows edge n+1.
- R5: With every strobe, `pix_idx_hi` equals `pix_idx + NPIX/2`. This is the index of the second half in parallel mode.
- R6: When the next request is already pending, the interval between consecutive first rising edges equals clamp(`int_req`) + `RST_CLKS`·2·`HALF` system cycles.
- R7: clamp() limits `int_req` to at least (n−`RST_CLKS`)·2·`HALF`+`GAP_CYC`, using the n of the frame just finished, and to at most `MAX_INT`. At each reported launch, `int_clamped` becomes 1 if either limit was applied and 0 otherwise.
- R8: After reset, a frame of n+1 edges starts without any request. It produces no `pix_strobe` and no `frame_done`.
- R9: `frame_done` is a one-cycle pulse during the high phase of edge n+1 of a reported frame. `busy` is low on the following cycle.
- R10: While reset is asserted, `busy`, `sns_clk`, `sns_start` and `pix_strobe` are low. A request made while `busy` is high is held and launches the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle frame request |
| par_mode | input | 1 | 1 = both halves read in parallel, 0 = serial |
| int_req | input | INT_W | Requested integration period in system cycles |
| sns_clk | output | 1 | Sensor pixel clock |
| sns_start | output | 1 | Sensor start pulse |
| pix_strobe | output | 1 | Converter sample strobe, one per pixel |
| pix_idx | output | IDX_W | Pixel index for the strobe |
| pix_idx_hi | output | IDX_W | Companion index in the upper half |
| frame_done | output | 1 | End of a reported frame |
| busy | output | 1 | A frame (lead-in or clocking) is in progress |
| int_clamped | output | 1 | Last reported launch had its period clamped |

## Verification
On every cycle, the assertions check the clock-phase lengths, that the clock is quiet when idle, and that the start pulse is placed against the clock edges. They also check the one-cycle width of the strobe, that `busy` drops after `frame_done`, and a lower bound on the start-to-start spacing. Other properties need whole frames, so only the bench's sweeps over both modes and over integration requests below, at and above each limit can show them. These are the exact start-to-start interval, the clamp flag, the edge and strobe counts, the index order and the silent flush frame.

// File: rtl/linsens_rdctl.sv
module linsens_rdctl #(
  parameter int NPIX     = 256,
  parameter int RST_CLKS = 18,
  parameter int HALF     = 8,
  parameter int GAP_CYC  = 2500,
  parameter int MAX_INT  = 12500000,
  parameter int STB_DLY  = 12,
  parameter int INT_W    = 24,
  localparam int IDX_W   = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             par_mode,
  input  logic [INT_W-1:0] int_req,
  output logic             sns_clk,
  output logic             sns_start,
  output logic             pix_strobe,
  output logic [IDX_W-1:0] pix_idx,
  output logic [IDX_W-1:0] pix_idx_hi,
  output logic             frame_done,
  output logic             busy,
  output logic             int_clamped
);

  localparam int P  = 2 * HALF;
  localparam int PW = $clog2(P) + 1;
  localparam int EW = $clog2(NPIX + 2);
  localparam int TW = INT_W + 2;
  localparam logic [TW-1:0] MIN_SER = TW'((NPIX - RST_CLKS) * P + GAP_CYC);
  localparam logic [TW-1:0] MIN_PAR = TW'((NPIX / 2 - RST_CLKS) * P + GAP_CYC);
  localparam logic [TW-1:0] MAX_T   = TW'(MAX_INT);
  localparam logic [TW-1:0] OFFS    = TW'(RST_CLKS * P);
  localparam logic [TW-1:0] LEADW   = TW'(HALF + 1);

  typedef enum logic [1:0] {S_WAIT, S_LEAD, S_RUN} state_t;

  state_t          st;
  logic [PW-1:0]   ph;
  logic [EW-1:0]   ecnt, nf, em1;
  logic [TW-1:0]   tcnt, lo_lim, int_x, int_c, due;
  logic            pend, flush, mode_q, clamp_q;
  logic            launch, lead_end, run_end, wrap, hi_ph;

  assign nf       = mode_q ? EW'(NPIX / 2) : EW'(NPIX);
  assign int_x    = TW'(int_req);
  assign lo_lim   = mode_q ? MIN_PAR : MIN_SER;
  assign int_c    = (int_x < lo_lim) ? lo_lim : (int_x > MAX_T) ? MAX_T : int_x;
  assign due      = int_c + OFFS - LEADW;
  assign launch   = (st == S_WAIT) && (flush || pend) && (tcnt >= due);
  assign lead_end = (st == S_LEAD) && (ph == PW'(HALF - 1));
  assign run_end  = (st == S_RUN) && (ecnt == nf + EW'(1)) && (ph == PW'(HALF - 1));
  assign wrap     = (st == S_RUN) && (ph == PW'(P - 1));
  assign hi_ph    = ph < PW'(HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      ph      <= '0;
      ecnt    <= '0;
      tcnt    <= '1;
      pend    <= 1'b0;
      flush   <= 1'b1;
      mode_q  <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      pend <= start_req | (pend & ~(launch & ~flush));
      if (lead_end)    tcnt <= '0;
      else if (~&tcnt) tcnt <= tcnt + TW'(1);
      case (st)
        S_WAIT: if (launch) begin
          st     <= S_LEAD;
          ph     <= '0;
          mode_q <= par_mode;
          if (!flush) clamp_q <= (int_x < lo_lim) || (int_x > MAX_T);
        end
        S_LEAD: if (lead_end) begin
          st   <= S_RUN;
          ph   <= '0;
          ecnt <= EW'(1);
        end else ph <= ph + PW'(1);
        S_RUN: if (run_end) begin
          st    <= S_WAIT;
          flush <= 1'b0;
        end else if (wrap) begin
          ph   <= '0;
          ecnt <= ecnt + EW'(1);
        end else ph <= ph + PW'(1);
        default: st <= S_WAIT;
      endcase
    end
  end

  assign em1         = ecnt - EW'(1);
  assign sns_clk     = (st == S_RUN) && hi_ph;
  assign sns_start   = (st == S_LEAD) || ((st == S_RUN) && (ecnt == EW'(1)) && hi_ph);
  assign pix_strobe  = (st == S_RUN) && !flush && (ph == PW'(STB_DLY)) && (ecnt <= nf);
  assign pix_idx     = em1[IDX_W-1:0];
  assign pix_idx_hi  = pix_idx + IDX_W'(NPIX / 2);
  assign frame_done  = run_end && !flush;
  assign busy        = (st != S_WAIT);
  assign int_clamped = clamp_q;

endmodule

// File: rtl/linsens_rdctl_chk.sv
module linsens_rdctl_chk #(
  parameter int HALF   = 8,
  parameter int MIN_SS = 4548
) (
  input logic clk,
  input logic rst_n,
  input logic sns_clk,
  input logic sns_start,
  input logic pix_strobe,
  input logic frame_done,
  input logic busy
);

  int unsigned hi_cnt, lo_cnt, gap_cnt;
  logic        start_p, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= 0;
      lo_cnt  <= 0;
      gap_cnt <= 0;
      start_p <= 1'b0;
      seen    <= 1'b0;
    end else begin
      hi_cnt  <= sns_clk ? hi_cnt + 1 : 0;
      lo_cnt  <= sns_clk ? 0 : lo_cnt + 1;
      start_p <= sns_start;
      if (sns_start && !start_p) begin
        gap_cnt <= 1;
        seen    <= 1'b1;
      end else if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sns_clk);
  p_high_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sns_clk) |-> hi_cnt == HALF);
  p_low_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sns_clk) && !sns_start) |-> lo_cnt == HALF);
  p_start_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sns_start) |-> !sns_clk);
  p_start_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sns_start) |-> $fell(sns_clk));
  p_strobe_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> !pix_strobe);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
  p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sns_start) && seen) |-> gap_cnt >= MIN_SS);

endmodule

bind linsens_rdctl linsens_rdctl_chk #(
  .HALF(HALF),
  .MIN_SS((NPIX / 2) * 2 * HALF + GAP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sns_clk(sns_clk), .sns_start(sns_start),
  .pix_strobe(pix_strobe), .frame_done(frame_done), .busy(busy)
);

// File: tb/linsens_rdctl_bench.sv
module linsens_rdctl_bench;
  localparam int NPIX = 16, RST = 3, HALF = 2, GAP = 6, MAXI = 300, STB = 1, IW = 12;
  localparam int IDX_W = $clog2(NPIX);
  localparam int P = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, par_mode = 1'b0;
  logic [IW-1:0] int_req = '0;
  logic sns_clk, sns_start, pix_strobe, frame_done, busy, int_clamped;
  logic [IDX_W-1:0] pix_idx, pix_idx_hi;

  always #4 clk = ~clk;

  linsens_rdctl #(.NPIX(NPIX), .RST_CLKS(RST), .HALF(HALF), .GAP_CYC(GAP),
                  .MAX_INT(MAXI), .STB_DLY(STB), .INT_W(IW)) u_linsens_rdctl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .par_mode(par_mode),
    .int_req(int_req), .sns_clk(sns_clk), .sns_start(sns_start),
    .pix_strobe(pix_strobe), .pix_idx(pix_idx), .pix_idx_hi(pix_idx_hi),
    .frame_done(frame_done), .busy(busy), .int_clamped(int_clamped));

  int checks = 0, fails = 0;
  int cyc = 0, last_rise = 0, prev_e1 = 0, last_int = -1;
  int rises = 0, strobes = 0, fbad = 0, dones = 0, bad_done = 0;
  int f_rises = 0, f_strobes = 0, f_bad = 0;
  bit have_e1 = 0, sclk_p = 0, done_p = 0, tmo = 0;

  always @(posedge clk) begin
    logic [IDX_W-1:0] hi_exp;
    if (rst_n) begin
      if (sns_clk && !sclk_p) begin
        if (sns_start) begin
          if (have_e1) last_int = cyc - prev_e1;
          prev_e1 = cyc; have_e1 = 1;
          rises = 0; strobes = 0; fbad = 0;
        end
        rises++;
        last_rise = cyc;
      end
      if (pix_strobe) begin
        hi_exp = pix_idx + IDX_W'(NPIX / 2);
        if (cyc - last_rise != STB || int'(pix_idx) != strobes || pix_idx_hi != hi_exp) fbad++;
        strobes++;
      end
      if (done_p && busy) bad_done++;
      if (frame_done) begin
        dones++; f_rises = rises; f_strobes = strobes; f_bad = fbad;
      end
      done_p = frame_done;
      sclk_p = sns_clk;
    end
    cyc++;
    if (cyc > 150000) tmo = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy, "R10 busy in reset", busy, 0);
    chk(!sns_clk && !sns_start, "R10 sensor pins in reset", sns_clk, 0);
    chk(!pix_strobe, "R10 strobe in reset", pix_strobe, 0);
    rst_n = 1'b1;
    while (!busy && !tmo) @(negedge clk);
    chk(busy, "R8 flush starts unrequested", busy, 1);
    while (busy && !tmo) @(negedge clk);
    chk(rises == NPIX + 1, "R8 flush edge count", rises, NPIX + 1);
    chk(strobes == 0, "R8 flush strobes", strobes, 0);
    chk(dones == 0, "R8 flush done pulses", dones, 0);

    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 7; k++) begin
        int nf, mn, v, clamped, texp, target;
        bit cl;
        nf = m ? NPIX / 2 : NPIX;
        mn = (nf - RST) * P + GAP;
        case (k)
          0: v = 0;
          1: v = mn - 1;
          2: v = mn;
          3: v = mn + 7;
          4: v = MAXI;
          5: v = MAXI + 1;
          default: v = (1 << IW) - 1;
        endcase
        clamped = (v < mn) ? mn : (v > MAXI) ? MAXI : v;
        cl = (v < mn) || (v > MAXI);
        texp = clamped + RST * P;
        @(negedge clk);
        par_mode = m[0];
        int_req = IW'(v);
        target = dones + 2;
        pulse_req();
        while (!busy && !tmo) @(negedge clk);
        pulse_req();
        while (dones < target && !tmo) @(negedge clk);
        chk(last_int == texp, $sformatf("R6 R10 interval m%0d v%0d", m, v), last_int, texp);
        chk(int_clamped == cl, $sformatf("R7 clamp flag m%0d v%0d", m, v), int_clamped, cl);
        chk(f_rises == nf + 1, $sformatf("R3 edge count m%0d", m), f_rises, nf + 1);
        chk(f_strobes == nf, $sformatf("R4 strobe count m%0d", m), f_strobes, nf);
        chk(f_bad == 0, $sformatf("R4 R5 strobe timing/index m%0d", m), f_bad, 0);
        while (busy && !tmo) @(negedge clk);
        chk(!sns_clk, "R1 clock idles low", sns_clk, 0);
      end
    end
    chk(bad_done == 0, "R9 busy after frame_done", bad_done, 0);
    if (tmo) chk(0, "watchdog", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 160000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule